// File: doc/BRIEF.md
# Interrupt Source Event State Table

This block keeps a two-bit event state and a routing entry for each source in a bank of interrupt sources. Upstream logic presents trigger events and end-of-interrupt (EOI) requests, each tagged with a source number. For every trigger the block decides whether to forward it, fold it into an event already outstanding, or drop it. A forwarded event leaves on a valid/ready output that carries the source number and the routing fields of that source: event data, target CPU and priority.

The source number is 13 bits wide, giving an 8K number space. Only the lowest `NUM_SRC` numbers are built. A number at or above `NUM_SRC` refers to no source. Each source is either message-signalled (MSI) or level-signalled (LSI). An LSI source also has a level input that the block samples when an EOI arrives. A register-style port writes the routing entries, the masks and the state bits, and reads them back. After reset every source is off and masked. Software brings a source into service by writing its routing entry and then setting its state to ready.

Top module: `irq_source_state_table`

## Requirements
- R1: After reset every built source reads state 01 (off), its routing word reads 0x1 (mask bit 0 set, all other fields zero), and `ev_valid` is low.
- R2: An accepted trigger on an unmasked source in state 00 moves it to 10 and presents one event in the next cycle. The event carries the source number in `ev_src` and that source's event data, CPU and priority.
- R3: A trigger on a source in state 10 moves it to 11 without an event. A trigger on a source in state 11 leaves it at 11 without an event.
- R4: A trigger on a source in state 01 is dropped: no event is produced and the state stays 01.
- R5: An EOI on an MSI source in state 10 returns it to 00 without an event. An EOI on a source in state 00 or 01 changes nothing and produces no event.
- R6: An EOI on a source in state 11 clears it and re-triggers it. When the source is unmasked, it ends in 10 and exactly one event is presented.
- R7: An EOI on an LSI source in state 10 re-triggers the source when its level input is high: it ends in 10 and one event is presented. When the level is low, it ends in 00 and no event is presented.
- R8: A masked source never produces an event. A trigger on a masked source in state 00 leaves it at 00. A re-trigger caused by an EOI on a masked source leaves it at 00.
- R9: A trigger and an EOI for the same source in the same cycle are applied EOI first, then trigger. State 11 ends in 11 with one event. State 10 on an MSI source ends in 10 with one event.
- R10: When a trigger and an EOI for different sources are offered in the same cycle, the EOI is accepted and `trig_ready` is low. The trigger's source state does not change.
- R11: While `ev_valid` is high and `ev_ready` is low, the event fields hold steady, `trig_ready` and `eoi_ready` are low, and offered triggers change no state.
- R12: Triggers, EOIs and configuration writes whose source number is `NUM_SRC` or above have no effect on any source. Configuration reads at such numbers return zero.
- R13: The configuration field codes are 0 for the routing word, 1 for event data and 2 for the state. The routing word has the mask at bit 0, the LSI flag at bit 1, the priority starting at bit 2 and the CPU starting at bit 16. The state field is writable and reads back in bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_valid | input | 1 | Trigger event offered |
| trig_src | input | SRC_W | Source number of the trigger |
| trig_ready | output | 1 | Trigger accepted this cycle when valid |
| eoi_valid | input | 1 | EOI request offered |
| eoi_src | input | SRC_W | Source number of the EOI |
| eoi_ready | output | 1 | EOI accepted this cycle when valid |
| lsi_level | input | NUM_SRC | Current line level of each LSI source |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | SRC_W | Source number for configuration access |
| cfg_field | input | 2 | Field select: 0 routing, 1 event data, 2 state |
| cfg_wdata | input | DATA_W | Configuration write data |
| cfg_rdata | output | DATA_W | Read data for the selected source and field |
| ev_valid | output | 1 | Forwarded event present |
| ev_ready | input | 1 | Consumer takes the event |
| ev_src | output | SRC_W | Source number of the event |
| ev_eisn | output | EISN_W | Event data of the source |
| ev_cpu | output | CPU_W | Target CPU of the source |
| ev_prio | output | PRIO_W | Priority of the source |

## Verification
A state bit held wrongly stays invisible until the next trigger or EOI on that source. It then shows either as an extra event or as a missing event one cycle after the request. The bench therefore reads the state field back after every step instead of relying on events alone. A wrong payload selection shows on `ev_src` or the routing fields in the very cycle the event appears. Arbitration faults show in the `trig_ready`/`eoi_ready` values sampled before the edge, or in the state of the losing source read afterward.

// File: rtl/isst_pkg.sv
package isst_pkg;

  typedef enum logic [1:0] {
    PQ_READY  = 2'b00,
    PQ_OFF    = 2'b01,
    PQ_PEND   = 2'b10,
    PQ_QUEUED = 2'b11
  } pq_e;

  typedef struct packed {
    pq_e  nxt;
    logic fire;
  } pq_step_t;

  localparam logic [1:0] FLD_ROUTE = 2'd0;
  localparam logic [1:0] FLD_EISN  = 2'd1;
  localparam logic [1:0] FLD_PQ    = 2'd2;

  localparam int ROUTE_MASK_BIT = 0;
  localparam int ROUTE_LSI_BIT  = 1;
  localparam int ROUTE_PRIO_LSB = 2;
  localparam int ROUTE_CPU_LSB  = 16;

  // Effect of one trigger on a source state.
  function automatic pq_step_t trig_step(input pq_e cur, input logic masked);
    pq_step_t r;
    r.nxt  = cur;
    r.fire = 1'b0;
    case (cur)
      PQ_READY: begin
        if (!masked) begin
          r.nxt  = PQ_PEND;
          r.fire = 1'b1;
        end
      end
      PQ_PEND:   r.nxt = PQ_QUEUED;
      PQ_QUEUED: r.nxt = PQ_QUEUED;
      default:   r.nxt = cur;
    endcase
    return r;
  endfunction

  // Effect of one EOI; a re-trigger is a trigger applied to a cleared state.
  function automatic pq_step_t eoi_step(input pq_e cur, input logic masked,
                                        input logic level_hi);
    pq_step_t r;
    r.nxt  = cur;
    r.fire = 1'b0;
    case (cur)
      PQ_PEND: begin
        if (level_hi) r = trig_step(PQ_READY, masked);
        else          r.nxt = PQ_READY;
      end
      PQ_QUEUED: r = trig_step(PQ_READY, masked);
      default:   r.nxt = cur;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/isst_route_table.sv
module isst_route_table
  import isst_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int IDX_W   = 6,
  parameter int EISN_W  = 32,
  parameter int CPU_W   = 12,
  parameter int PRIO_W  = 3,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [1:0]        wr_field,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  ev_idx,
  output logic [EISN_W-1:0] ev_eisn,
  output logic [CPU_W-1:0]  ev_cpu,
  output logic [PRIO_W-1:0] ev_prio,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_route,
  output logic [DATA_W-1:0] rd_eisn,
  output logic [NUM_SRC-1:0] mask_vec,
  output logic [NUM_SRC-1:0] lsi_vec
);

  logic [EISN_W-1:0] eisn_q [NUM_SRC];
  logic [CPU_W-1:0]  cpu_q  [NUM_SRC];
  logic [PRIO_W-1:0] prio_q [NUM_SRC];
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] lsi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
      lsi_q  <= '0;
      for (int i = 0; i < NUM_SRC; i++) begin
        eisn_q[i] <= '0;
        cpu_q[i]  <= '0;
        prio_q[i] <= '0;
      end
    end else if (wr_en) begin
      if (wr_field == FLD_ROUTE) begin
        mask_q[wr_idx] <= wr_data[ROUTE_MASK_BIT];
        lsi_q[wr_idx]  <= wr_data[ROUTE_LSI_BIT];
        prio_q[wr_idx] <= wr_data[ROUTE_PRIO_LSB +: PRIO_W];
        cpu_q[wr_idx]  <= wr_data[ROUTE_CPU_LSB +: CPU_W];
      end else if (wr_field == FLD_EISN) begin
        eisn_q[wr_idx] <= wr_data[EISN_W-1:0];
      end
    end
  end

  assign ev_eisn  = eisn_q[ev_idx];
  assign ev_cpu   = cpu_q[ev_idx];
  assign ev_prio  = prio_q[ev_idx];
  assign mask_vec = mask_q;
  assign lsi_vec  = lsi_q;

  always_comb begin
    rd_route = '0;
    rd_route[ROUTE_MASK_BIT]           = mask_q[rd_idx];
    rd_route[ROUTE_LSI_BIT]            = lsi_q[rd_idx];
    rd_route[ROUTE_PRIO_LSB +: PRIO_W] = prio_q[rd_idx];
    rd_route[ROUTE_CPU_LSB +: CPU_W]   = cpu_q[rd_idx];
    rd_eisn = '0;
    rd_eisn[EISN_W-1:0] = eisn_q[rd_idx];
  end

  // Route word bits outside the defined fields are ignored on write.
  logic unused_wdata;
  assign unused_wdata = ^wr_data;

endmodule

// File: rtl/isst_pq_table.sv
module isst_pq_table
  import isst_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int IDX_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trig_go,
  input  logic [IDX_W-1:0]   trig_idx,
  input  logic               eoi_go,
  input  logic [IDX_W-1:0]   eoi_idx,
  input  logic [NUM_SRC-1:0] mask_vec,
  input  logic [NUM_SRC-1:0] lsi_vec,
  input  logic [NUM_SRC-1:0] lsi_level,
  input  logic               cfg_pq_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [1:0]         cfg_pq,
  output logic [1:0]         cfg_pq_rd,
  output logic               fire,
  output logic [IDX_W-1:0]   fire_idx
);

  pq_e      pq_q [NUM_SRC];
  pq_step_t eoi_res;
  pq_step_t trig_res;
  pq_e      trig_base;
  logic     same_src;
  logic     eoi_fire;
  logic     trig_fire;

  // EOI is evaluated first; a same-source trigger sees the EOI result.
  always_comb begin
    eoi_res   = eoi_step(pq_q[eoi_idx], mask_vec[eoi_idx],
                         lsi_vec[eoi_idx] && lsi_level[eoi_idx]);
    same_src  = eoi_go && (eoi_idx == trig_idx);
    trig_base = same_src ? eoi_res.nxt : pq_q[trig_idx];
    trig_res  = trig_step(trig_base, mask_vec[trig_idx]);
  end

  assign eoi_fire  = eoi_go && eoi_res.fire;
  assign trig_fire = trig_go && trig_res.fire;
  assign fire      = eoi_fire || trig_fire;
  assign fire_idx  = eoi_fire ? eoi_idx : trig_idx;
  assign cfg_pq_rd = pq_q[cfg_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SRC; i++) pq_q[i] <= PQ_OFF;
    end else begin
      if (eoi_go)    pq_q[eoi_idx]  <= eoi_res.nxt;
      if (trig_go)   pq_q[trig_idx] <= trig_res.nxt;
      if (cfg_pq_we) pq_q[cfg_idx]  <= pq_e'(cfg_pq);
    end
  end

  // R9: EOI-then-trigger ordering never yields two events in one cycle.
  p_single_fire_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(eoi_fire && trig_fire));

  // R4: a trigger on an off source leaves it off.
  p_off_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_go && !same_src && !cfg_pq_we && pq_q[trig_idx] == PQ_OFF)
    |=> (pq_q[$past(trig_idx)] == PQ_OFF));

endmodule

// File: rtl/isst_event_out.sv
module isst_event_out #(
  parameter int SRC_W  = 13,
  parameter int EISN_W = 32,
  parameter int CPU_W  = 12,
  parameter int PRIO_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SRC_W-1:0]  in_src,
  input  logic [EISN_W-1:0] in_eisn,
  input  logic [CPU_W-1:0]  in_cpu,
  input  logic [PRIO_W-1:0] in_prio,
  output logic              slot_free,
  output logic              ev_valid,
  input  logic              ev_ready,
  output logic [SRC_W-1:0]  ev_src,
  output logic [EISN_W-1:0] ev_eisn,
  output logic [CPU_W-1:0]  ev_cpu,
  output logic [PRIO_W-1:0] ev_prio
);

  assign slot_free = !ev_valid || ev_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_valid <= 1'b0;
      ev_src   <= '0;
      ev_eisn  <= '0;
      ev_cpu   <= '0;
      ev_prio  <= '0;
    end else if (load) begin
      ev_valid <= 1'b1;
      ev_src   <= in_src;
      ev_eisn  <= in_eisn;
      ev_cpu   <= in_cpu;
      ev_prio  <= in_prio;
    end else if (ev_ready) begin
      ev_valid <= 1'b0;
    end
  end

  // R11: no event is loaded over one the consumer has not taken.
  p_no_overwrite_r11: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> slot_free);

  // R11: a stalled event keeps its fields.
  p_hold_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_src) && $stable(ev_eisn)
                                 && $stable(ev_cpu) && $stable(ev_prio)));

endmodule

// File: rtl/irq_source_state_table.sv
module irq_source_state_table
  import isst_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int SRC_W   = 13,
  parameter int EISN_W  = 32,
  parameter int CPU_W   = 12,
  parameter int PRIO_W  = 3,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trig_valid,
  input  logic [SRC_W-1:0]   trig_src,
  output logic               trig_ready,
  input  logic               eoi_valid,
  input  logic [SRC_W-1:0]   eoi_src,
  output logic               eoi_ready,
  input  logic [NUM_SRC-1:0] lsi_level,
  input  logic               cfg_wr,
  input  logic [SRC_W-1:0]   cfg_addr,
  input  logic [1:0]         cfg_field,
  input  logic [DATA_W-1:0]  cfg_wdata,
  output logic [DATA_W-1:0]  cfg_rdata,
  output logic               ev_valid,
  input  logic               ev_ready,
  output logic [SRC_W-1:0]   ev_src,
  output logic [EISN_W-1:0]  ev_eisn,
  output logic [CPU_W-1:0]   ev_cpu,
  output logic [PRIO_W-1:0]  ev_prio
);

  localparam int IDX_W = $clog2(NUM_SRC);

  logic               slot_free;
  logic               trig_inr, eoi_inr, cfg_inr;
  logic               trig_go, eoi_go;
  logic [IDX_W-1:0]   trig_idx, eoi_idx, cfg_idx, fire_idx;
  logic               fire;
  logic               route_we, pq_we;
  logic [NUM_SRC-1:0] mask_vec, lsi_vec;
  logic [EISN_W-1:0]  rt_eisn;
  logic [CPU_W-1:0]   rt_cpu;
  logic [PRIO_W-1:0]  rt_prio;
  logic [DATA_W-1:0]  rd_route, rd_eisn;
  logic [1:0]         rd_pq;

  assign trig_inr = int'(trig_src) < NUM_SRC;
  assign eoi_inr  = int'(eoi_src) < NUM_SRC;
  assign cfg_inr  = int'(cfg_addr) < NUM_SRC;
  assign trig_idx = trig_src[IDX_W-1:0];
  assign eoi_idx  = eoi_src[IDX_W-1:0];
  assign cfg_idx  = cfg_addr[IDX_W-1:0];

  // EOI wins the single event slot; a trigger for another source waits.
  assign eoi_ready  = slot_free;
  assign trig_ready = slot_free && !(eoi_valid && (eoi_src != trig_src));
  assign eoi_go     = eoi_valid && eoi_ready && eoi_inr;
  assign trig_go    = trig_valid && trig_ready && trig_inr;

  assign route_we = cfg_wr && cfg_inr && (cfg_field == FLD_ROUTE || cfg_field == FLD_EISN);
  assign pq_we    = cfg_wr && cfg_inr && (cfg_field == FLD_PQ);

  isst_route_table #(
    .NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .EISN_W(EISN_W),
    .CPU_W(CPU_W), .PRIO_W(PRIO_W), .DATA_W(DATA_W)
  ) u_route (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (route_we),
    .wr_idx   (cfg_idx),
    .wr_field (cfg_field),
    .wr_data  (cfg_wdata),
    .ev_idx   (fire_idx),
    .ev_eisn  (rt_eisn),
    .ev_cpu   (rt_cpu),
    .ev_prio  (rt_prio),
    .rd_idx   (cfg_idx),
    .rd_route (rd_route),
    .rd_eisn  (rd_eisn),
    .mask_vec (mask_vec),
    .lsi_vec  (lsi_vec)
  );

  isst_pq_table #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pq (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_go   (trig_go),
    .trig_idx  (trig_idx),
    .eoi_go    (eoi_go),
    .eoi_idx   (eoi_idx),
    .mask_vec  (mask_vec),
    .lsi_vec   (lsi_vec),
    .lsi_level (lsi_level),
    .cfg_pq_we (pq_we),
    .cfg_idx   (cfg_idx),
    .cfg_pq    (cfg_wdata[1:0]),
    .cfg_pq_rd (rd_pq),
    .fire      (fire),
    .fire_idx  (fire_idx)
  );

  isst_event_out #(
    .SRC_W(SRC_W), .EISN_W(EISN_W), .CPU_W(CPU_W), .PRIO_W(PRIO_W)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (fire),
    .in_src    (SRC_W'(fire_idx)),
    .in_eisn   (rt_eisn),
    .in_cpu    (rt_cpu),
    .in_prio   (rt_prio),
    .slot_free (slot_free),
    .ev_valid  (ev_valid),
    .ev_ready  (ev_ready),
    .ev_src    (ev_src),
    .ev_eisn   (ev_eisn),
    .ev_cpu    (ev_cpu),
    .ev_prio   (ev_prio)
  );

  always_comb begin
    cfg_rdata = '0;
    if (cfg_inr) begin
      case (cfg_field)
        FLD_ROUTE: cfg_rdata = rd_route;
        FLD_EISN:  cfg_rdata = rd_eisn;
        FLD_PQ:    cfg_rdata[1:0] = rd_pq;
        default:   cfg_rdata = '0;
      endcase
    end
  end

  // R8: the routing table never lets a masked source reach the output.
  p_masked_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !mask_vec[fire_idx]);

endmodule

// File: tb/irq_source_state_table_tb.sv
module irq_source_state_table_tb;

  localparam int NUM_SRC = 64;
  localparam int SRC_W   = 13;

  logic clk = 1'b0;
  logic rst_n;
  logic trig_valid, eoi_valid, cfg_wr, ev_ready;
  logic [SRC_W-1:0] trig_src, eoi_src, cfg_addr;
  logic trig_ready, eoi_ready;
  logic [NUM_SRC-1:0] lsi_level;
  logic [1:0] cfg_field;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic ev_valid;
  logic [SRC_W-1:0] ev_src;
  logic [31:0] ev_eisn;
  logic [11:0] ev_cpu;
  logic [2:0] ev_prio;

  int n_tests = 0;
  int n_fail  = 0;
  logic c_valid, c_trdy, c_erdy;
  logic [SRC_W-1:0] c_src;
  logic [31:0] c_eisn;
  logic [11:0] c_cpu;
  logic [2:0] c_prio;

  always #10 clk = ~clk;

  irq_source_state_table u_dut (
    .clk(clk), .rst_n(rst_n),
    .trig_valid(trig_valid), .trig_src(trig_src), .trig_ready(trig_ready),
    .eoi_valid(eoi_valid), .eoi_src(eoi_src), .eoi_ready(eoi_ready),
    .lsi_level(lsi_level),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_field(cfg_field),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_src(ev_src),
    .ev_eisn(ev_eisn), .ev_cpu(ev_cpu), .ev_prio(ev_prio)
  );

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input int addr, input logic [1:0] fld, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = SRC_W'(addr); cfg_field = fld; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input int addr, input logic [1:0] fld, output logic [31:0] d);
    cfg_addr = SRC_W'(addr); cfg_field = fld;
    #1;
    d = cfg_rdata;
  endtask

  task automatic check_pq(input string req, input int src, input int exp);
    logic [31:0] d;
    cfg_read(src, 2'd2, d);
    check(req, $sformatf("state of source %0d", src), d, exp);
  endtask

  // One cycle of stimulus; captures readies before the edge and outputs after it.
  task automatic step(input bit t_en, input int t_src, input bit e_en, input int e_src);
    @(negedge clk);
    trig_valid = t_en; trig_src = SRC_W'(t_src);
    eoi_valid  = e_en; eoi_src  = SRC_W'(e_src);
    #1;
    c_trdy = trig_ready; c_erdy = eoi_ready;
    @(negedge clk);
    c_valid = ev_valid; c_src = ev_src; c_eisn = ev_eisn; c_cpu = ev_cpu; c_prio = ev_prio;
    trig_valid = 1'b0; eoi_valid = 1'b0;
  endtask

  // Routing word: bit0 mask, bit1 LSI, prio from bit2, cpu from bit16 (R13).
  task automatic setup(input int src, input bit lsi, input bit masked, input int prio,
                       input int cpu, input logic [31:0] eisn);
    cfg_write(src, 2'd0, (32'(cpu) << 16) | (32'(prio) << 2) | (32'(lsi) << 1) | 32'(masked));
    cfg_write(src, 2'd1, eisn);
    cfg_write(src, 2'd2, 32'd0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1", "ev_valid after reset", ev_valid, 0);
    check_pq("R1", 0, 1);
    check_pq("R1", NUM_SRC - 1, 1);
    cfg_read(5, 2'd0, d);
    check("R1", "routing word after reset", d, 32'h1);
  endtask

  task automatic t_cfg();
    logic [31:0] d;
    cfg_write(7, 2'd0, 32'h0ABC_0016);
    cfg_read(7, 2'd0, d);
    check("R13", "routing word readback", d, 32'h0ABC_0016);
    cfg_write(7, 2'd1, 32'hDEAD_BEEF);
    cfg_read(7, 2'd1, d);
    check("R13", "event data readback", d, 32'hDEAD_BEEF);
    cfg_write(7, 2'd2, 32'd3);
    check_pq("R13", 7, 3);
  endtask

  task automatic t_msi_cycle();
    setup(5, 0, 0, 6, 7, 32'hA5A5_0005);
    step(1, 5, 0, 0);
    check("R2", "event valid", c_valid, 1);
    check("R2", "event source", c_src, 5);
    check("R2", "event data", c_eisn, 32'hA5A5_0005);
    check("R2", "event cpu", c_cpu, 7);
    check("R2", "event prio", c_prio, 6);
    check_pq("R2", 5, 2);
    step(1, 5, 0, 0);
    check("R3", "no event on pending", c_valid, 0);
    check_pq("R3", 5, 3);
    step(1, 5, 0, 0);
    check("R3", "no event on queued", c_valid, 0);
    check_pq("R3", 5, 3);
    step(0, 0, 1, 5);
    check("R6", "event on EOI of queued", c_valid, 1);
    check("R6", "event source", c_src, 5);
    check_pq("R6", 5, 2);
    step(0, 0, 1, 5);
    check("R5", "no event on EOI of pending", c_valid, 0);
    check_pq("R5", 5, 0);
    step(0, 0, 1, 5);
    check("R5", "no event on EOI of ready", c_valid, 0);
    check_pq("R5", 5, 0);
  endtask

  task automatic t_off();
    step(1, 9, 0, 0);
    check("R4", "no event on off source", c_valid, 0);
    check_pq("R4", 9, 1);
    step(0, 0, 1, 9);
    check("R5", "no event on EOI of off", c_valid, 0);
    check_pq("R5", 9, 1);
  endtask

  task automatic t_lsi();
    setup(12, 1, 0, 2, 3, 32'h0000_1212);
    step(1, 12, 0, 0);
    check("R7", "LSI first event", c_valid, 1);
    lsi_level[12] = 1'b1;
    step(0, 0, 1, 12);
    check("R7", "LSI re-event with level high", c_valid, 1);
    check("R7", "LSI re-event source", c_src, 12);
    check_pq("R7", 12, 2);
    lsi_level[12] = 1'b0;
    step(0, 0, 1, 12);
    check("R7", "LSI no event with level low", c_valid, 0);
    check_pq("R7", 12, 0);
  endtask

  task automatic t_mask();
    setup(20, 0, 1, 1, 1, 32'h20);
    step(1, 20, 0, 0);
    check("R8", "masked trigger event", c_valid, 0);
    check_pq("R8", 20, 0);
    cfg_write(20, 2'd2, 32'd3);
    step(0, 0, 1, 20);
    check("R8", "masked re-trigger event", c_valid, 0);
    check_pq("R8", 20, 0);
  endtask

  task automatic t_same_cycle();
    setup(30, 0, 0, 4, 30, 32'h3030);
    step(1, 30, 0, 0);
    step(1, 30, 0, 0);
    check_pq("R9", 30, 3);
    step(1, 30, 1, 30);
    check("R9", "one event from queued", c_valid, 1);
    check("R9", "event source", c_src, 30);
    check_pq("R9", 30, 3);
    step(0, 0, 1, 30);
    check_pq("R9", 30, 2);
    step(1, 30, 1, 30);
    check("R9", "one event from pending", c_valid, 1);
    check_pq("R9", 30, 2);
  endtask

  task automatic t_conflict();
    setup(40, 0, 0, 1, 40, 32'h4040);
    setup(41, 0, 0, 1, 41, 32'h4141);
    cfg_write(40, 2'd2, 32'd3);
    step(1, 41, 1, 40);
    check("R10", "trig_ready during EOI", c_trdy, 0);
    check("R10", "eoi_ready", c_erdy, 1);
    check("R10", "event from EOI source", c_src, 40);
    check_pq("R10", 41, 0);
    check_pq("R10", 40, 2);
    step(1, 41, 0, 0);
    check("R10", "delayed trigger event source", c_src, 41);
  endtask

  task automatic t_backpressure();
    logic [31:0] held;
    setup(50, 0, 0, 5, 50, 32'h5050);
    ev_ready = 1'b0;
    step(1, 50, 0, 0);
    check("R11", "event presented", c_valid, 1);
    held = c_eisn;
    step(1, 50, 0, 0);
    check("R11", "trig_ready while stalled", c_trdy, 0);
    check("R11", "eoi_ready while stalled", c_erdy, 0);
    check("R11", "event still valid", c_valid, 1);
    check("R11", "event data stable", c_eisn, held);
    check_pq("R11", 50, 2);
    @(negedge clk);
    ev_ready = 1'b1;
    @(negedge clk);
    check("R11", "event drained", ev_valid, 0);
  endtask

  task automatic t_range();
    logic [31:0] d;
    step(1, 13'h1FFF, 0, 0);
    check("R12", "top source number event", c_valid, 0);
    step(1, 100, 0, 0);
    check("R12", "out-of-range trigger event", c_valid, 0);
    step(0, 0, 1, 100);
    cfg_write(100, 2'd2, 32'd0);
    check_pq("R12", 36, 1);
    cfg_read(100, 2'd2, d);
    check("R12", "out-of-range state read", d, 0);
    cfg_read(100, 2'd0, d);
    check("R12", "out-of-range routing read", d, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; trig_valid = 1'b0; eoi_valid = 1'b0; cfg_wr = 1'b0;
    trig_src = '0; eoi_src = '0; cfg_addr = '0; cfg_field = '0; cfg_wdata = '0;
    lsi_level = '0; ev_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_msi_cycle();
    t_off();
    t_lsi();
    t_mask();
    t_same_cycle();
    t_conflict();
    t_backpressure();
    t_range();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule